// File: doc/BRIEF.md
# Parity-Preserving Reversible Gate Unit

This combinational unit evaluates one of four reversible, parity-preserving gates on a 4-line input vector. A 2-bit opcode selects the gate, and the output vector has the same width as the input. Two of the gates are 3-line gates: a double-fanout XOR gate and a controlled swap gate. The other two are 4×4 logic blocks. On the 3-line gates the fourth line passes through unchanged, so the parity rule still covers all four bits. Every gate is a bijection on the 16 possible input vectors.

A live parity comparator raises a fault flag when the XOR of the output lines differs from the XOR of the input lines. Any single-bit error on the outputs therefore shows up at once. A fault-injection mask is XORed onto the gate result before it leaves the unit, so the comparator can be exercised in the system. The unit has no clock and no state.

Top module: `ppr_gate_unit`

## Requirements
- R1: Line mapping: A=in_i[0], B=in_i[1], C=in_i[2], D=in_i[3], and P=out_o[0], Q=out_o[1], R=out_o[2], S=out_o[3]. The opcode encoding is 0 for the double-fanout gate, 1 for the controlled swap, 2 for block A and 3 for block B.
- R2: With opcode 0 and a zero mask, the outputs are P=A, Q=A^B, R=A^C and S=D.
- R3: With opcode 1 and a zero mask, P=A and S=D. When A=0, Q=B and R=C. When A=1, Q=C and R=B.
- R4: With opcode 2 and a zero mask, the outputs are P=~(A^B), Q=~B, R=(~B&C)^(B&D) and S=(~B&D)^(B&~C).
- R5: With opcode 3 and a zero mask, the outputs are P=(A&~C)^(B&C), Q=~(A^B), R=~C and S=P^D.
- R6: With a zero mask, the XOR of out_o equals the XOR of in_i for every opcode and input.
- R7: For each opcode with a zero mask, the 16 input vectors produce 16 distinct output vectors.
- R8: out_o is the selected gate result XORed bitwise with mask_i.
- R9: fault_o is high exactly when the XOR of out_o differs from the XOR of in_i. It is low for a zero mask, high for any one-bit mask and low for a two-bit mask.
- R10: The unit is purely combinational. out_o and fault_o follow a change of op_i, in_i or mask_i in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Gate select opcode |
| in_i | input | 4 | Input lines A..D |
| mask_i | input | 4 | Fault-injection mask XORed onto the outputs |
| out_o | output | 4 | Output lines P..S |
| fault_o | output | 1 | Parity mismatch between inputs and outputs |

## Verification
Every result of this unit is due in the cycle its inputs are applied, because no register sits on any path. The driver changes the inputs just after a rising edge and queues the expected outputs and flag. The monitor takes one item per falling edge, half a period later, so each comparison sees settled combinational values for exactly the stimulus that was queued. The bijection check runs after the sweep on the outputs the monitor captured.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int unsigned LINES   = 4;
  localparam int unsigned NUM_OPS = 4;
  localparam int unsigned OP_W    = $clog2(NUM_OPS);

  typedef logic [LINES-1:0] vec_t;

  typedef enum logic [OP_W-1:0] {
    OP_DUP  = 2'd0,
    OP_SWAP = 2'd1,
    OP_BLKA = 2'd2,
    OP_BLKB = 2'd3
  } op_e;
endpackage

// File: rtl/ppr_gate_bank.sv
module ppr_gate_bank
  import ppr_pkg::*;
(
  input  vec_t                     in_i,
  output logic [NUM_OPS-1:0][LINES-1:0] res_o
);
  logic a, b, c, d;
  assign a = in_i[0];
  assign b = in_i[1];
  assign c = in_i[2];
  assign d = in_i[3];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_gate
    if (g == int'(OP_DUP)) begin : g_dup
      assign res_o[g] = {d, a ^ c, a ^ b, a};
    end else if (g == int'(OP_SWAP)) begin : g_swap
      // control line A selects straight or crossed routing of B and C
      assign res_o[g] = {d, a ? b : c, a ? c : b, a};
    end else if (g == int'(OP_BLKA)) begin : g_blka
      assign res_o[g] = {(~b & d) ^ (b & ~c),
                         (~b & c) ^ (b & d),
                         ~b,
                         ~(a ^ b)};
    end else begin : g_blkb
      logic p;
      assign p = (a & ~c) ^ (b & c);
      assign res_o[g] = {p ^ d, ~c, ~(a ^ b), p};
    end
  end
endmodule

// File: rtl/ppr_out_sel.sv
module ppr_out_sel
  import ppr_pkg::*;
(
  input  logic [OP_W-1:0]               op_i,
  input  logic [NUM_OPS-1:0][LINES-1:0] res_i,
  input  vec_t                          mask_i,
  output vec_t                          out_o
);
  assign out_o = res_i[op_i] ^ mask_i;
endmodule

// File: rtl/ppr_parity_cmp.sv
module ppr_parity_cmp
  import ppr_pkg::*;
(
  input  vec_t in_i,
  input  vec_t out_i,
  output logic fault_o
);
  assign fault_o = (^in_i) ^ (^out_i);
endmodule

// File: rtl/ppr_gate_unit.sv
module ppr_gate_unit
  import ppr_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [LINES-1:0] in_i,
  input  logic [LINES-1:0] mask_i,
  output logic [LINES-1:0] out_o,
  output logic             fault_o
);
  logic [NUM_OPS-1:0][LINES-1:0] res;

  ppr_gate_bank u_bank (
    .in_i  (in_i),
    .res_o (res)
  );

  ppr_out_sel u_sel (
    .op_i   (op_i),
    .res_i  (res),
    .mask_i (mask_i),
    .out_o  (out_o)
  );

  ppr_parity_cmp u_cmp (
    .in_i    (in_i),
    .out_i   (out_o),
    .fault_o (fault_o)
  );
endmodule

// File: rtl/ppr_gate_unit_chk.sv
module ppr_gate_unit_chk
  import ppr_pkg::*;
(
  input logic [OP_W-1:0]  op_i,
  input logic [LINES-1:0] in_i,
  input logic [LINES-1:0] mask_i,
  input logic [LINES-1:0] out_o,
  input logic             fault_o
);
  always_comb begin
    if (!$isunknown({op_i, in_i, mask_i, out_o, fault_o})) begin
      if (mask_i == '0) begin
        p_parity_kept_r6: assert ((^out_o) == (^in_i));
        p_fault_quiet_r9: assert (!fault_o);
      end
      if ($countones(mask_i) == 1)
        p_fault_single_r9: assert (fault_o);
      if (op_i <= 2'd1 && !mask_i[0])
        p_ctrl_pass_r3: assert (out_o[0] == in_i[0]);
      if (op_i <= 2'd1 && !mask_i[3])
        p_line_d_pass_r2: assert (out_o[3] == in_i[3]);
    end
  end
endmodule

bind ppr_gate_unit ppr_gate_unit_chk u_chk (
  .op_i    (op_i),
  .in_i    (in_i),
  .mask_i  (mask_i),
  .out_o   (out_o),
  .fault_o (fault_o)
);

// File: tb/tb_ppr_gate_unit.sv
module tb_ppr_gate_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] op;
    logic [3:0] in;
    logic [3:0] mask;
    logic [3:0] exp_out;
    logic       exp_fault;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] op_i = '0;
  logic [3:0] in_i = '0;
  logic [3:0] mask_i = '0;
  logic [3:0] out_o;
  logic       fault_o;

  int checks = 0;
  int errors = 0;
  item_t q[$];
  logic [3:0] seen [64];
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppr_gate_unit dut (
    .op_i    (op_i),
    .in_i    (in_i),
    .mask_i  (mask_i),
    .out_o   (out_o),
    .fault_o (fault_o)
  );

  function automatic logic [3:0] ref_gate(input logic [1:0] op, input logic [3:0] v);
    logic a, b, c, d, p;
    a = v[0]; b = v[1]; c = v[2]; d = v[3];
    case (op)
      2'd0: return {d, a ^ c, a ^ b, a};                     // R2
      2'd1: return a ? {d, b, c, a} : {d, c, b, a};          // R3
      2'd2: return {b ? ~c : d, b ? d : c, ~b, ~(a ^ b)};    // R4
      default: begin                                         // R5
        p = c ? b : a;
        return {p ^ d, ~c, ~(a ^ b), p};
      end
    endcase
  endfunction

  task automatic drive(input logic [1:0] op, input logic [3:0] v, input logic [3:0] m);
    item_t it;
    @(posedge clk);
    #1;
    op_i = op; in_i = v; mask_i = m;
    it.op = op; it.in = v; it.mask = m;
    it.exp_out = ref_gate(op, v) ^ m;                        // R8
    it.exp_fault = ^m;                                       // R9
    q.push_back(it);
  endtask

  // Monitor: combinational results are due in the same cycle (R10)
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (out_o !== it.exp_out) begin
        errors++;
        $display("FAIL R2-5/R8 out op=%0d in=%h mask=%h: got %h exp %h",
                 it.op, it.in, it.mask, out_o, it.exp_out);
      end
      checks++;
      if (fault_o !== it.exp_fault) begin
        errors++;
        $display("FAIL R9 fault op=%0d in=%h mask=%h: got %b exp %b",
                 it.op, it.in, it.mask, fault_o, it.exp_fault);
      end
      if (it.mask == 4'h0) begin
        seen[{it.op, it.in}] = out_o;
        checks++;
        if ((^out_o) !== (^it.in)) begin                     // R6
          errors++;
          $display("FAIL R6 parity op=%0d in=%h: got %b exp %b",
                   it.op, it.in, ^out_o, ^it.in);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R1: idle vector, opcode 0, zero mask gives all-zero output and quiet flag
    @(negedge clk);
    checks++;
    if (out_o !== 4'h0 || fault_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: got %h/%b exp 0/0", out_o, fault_o);
    end
    for (int op = 0; op < 4; op++) begin
      for (int v = 0; v < 16; v++) begin
        drive(op[1:0], v[3:0], 4'h0);
        for (int b = 0; b < 4; b++) drive(op[1:0], v[3:0], 4'h1 << b);
        drive(op[1:0], v[3:0], 4'h3);
        drive(op[1:0], v[3:0], 4'hA);
      end
    end
    wait (q.size() == 0);
    @(negedge clk);
    // R7: bijection per opcode
    for (int op = 0; op < 4; op++) begin
      logic [15:0] hit;
      hit = '0;
      for (int v = 0; v < 16; v++) hit[seen[op*16+v]] = 1'b1;
      checks++;
      if (hit !== 16'hFFFF) begin
        errors++;
        $display("FAIL R7 bijection op=%0d: got %h exp ffff", op, hit);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule